// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block sits behind a test access port controller and lets an external debug host read and write a small bank of 32-bit trace-buffer registers. The host first loads a chain-select instruction and shifts in a chain number. It then loads the access instruction and shifts 40-bit frames through the access data register. Each frame holds a 32-bit data word, a 7-bit register address and a direction flag. On the update strobe the block acts on the frame. A write frame to a real register produces a one-cycle write strobe on a plain address/data bus. A read frame only records the address. That read is carried out on the capture strobe of the following scan, so each scan returns the value named by the scan before it.

Register 0 is an identification constant kept inside the block. Registers 1 to 8 live in the storage behind the bus. One of them, the trace RAM data port, moves its read pointer forward on every bus read. A host that streams RAM entries therefore names register 0 in its last frame, which does not touch the bus. Addresses above 8 read as zero and drop writes.

Top module: `jtag_reg_access`

## Requirements
- R1: After reset the chain number is all ones, so the access register is not selected. No bus strobe is high and `tdo` is 0.
- R2: While `ir_value` is 0x2 the 5-bit chain register is in the path. Capture loads the current chain number, shifting is LSB first, and update makes the shifted value the new chain number.
- R3: Capture, shift and update on the access register act only while `ir_value` is 0xC and the chain number is 0. At any other time they cause no bus strobe.
- R4: The access frame is 40 bits and shifts in and out LSB first. Bits [31:0] are data, bits [38:32] are the register address, and bit 39 is the direction (1 = write, 0 = read).
- R5: The update of a write frame to an address from 1 to 8 raises `bus_we` for exactly that update cycle. During that cycle `bus_addr` and `bus_wdata` carry the frame's address and data.
- R6: A write frame to address 0 or to any address above 8 raises no `bus_we`.
- R7: When the previous access scan was a read of an address from 1 to 8, the next capture raises `bus_re` for that one cycle with `bus_addr` set to that address. It loads `bus_rdata` into bits [31:0] of the frame and zero into bits [39:32].
- R8: A read of address 0 returns the identification parameter, and a read of an address above 8 returns zero. Neither raises `bus_re`, so the storage's read pointer does not move.
- R9: A capture that follows a write scan, or that comes before any read scan since reset, returns an all-zero frame and raises no `bus_re`.
- R10: `tdo` is 0 whenever neither the chain register nor the access register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one TAP step per enabled cycle |
| rst | input | 1 | Synchronous active-high reset |
| ir_value | input | 4 | Instruction held by the TAP controller |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, LSB of the selected register |
| bus_addr | output | 7 | Register address toward the storage |
| bus_wdata | output | 32 | Write data toward the storage |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe, advances the RAM read pointer at address 4 |
| bus_rdata | input | 32 | Read data from the storage, valid in the `bus_re` cycle |

## Verification
A corrupted pending-read record shows up in the next scan's captured frame. That means a wrong word on `tdo` in the first 32 shift cycles after capture, and often a stray or missing `bus_re` in the capture cycle itself. A bus event queue catches both within one scan. A wrong chain number or wrong qualifier decode either drops every later bus strobe or lets strobes through when they should be blocked. Extra RAM reads do not show at once. They appear later as a skipped entry, because the read pointer advances, so the bench checks the data returned by each consecutive RAM read.

// File: rtl/jrac_pkg.sv
package jrac_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    // Frame as it sits in the shift register; bit 0 leaves first on tdo.
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    // A read recorded at update, served at the next capture.
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } pend_t;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_IDENT = 2'd1,
        SRC_BUS  = 2'd2
    } rsrc_e;

    function automatic rsrc_e classify(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] nregs);
        if (a == '0)
            return SRC_IDENT;
        else if (a < nregs)
            return SRC_BUS;
        else
            return SRC_ZERO;
    endfunction

    function automatic logic writable(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] nregs);
        return (a != '0) && (a < nregs);
    endfunction

endpackage

// File: rtl/jrac_chain_select.sv
module jrac_chain_select #(
    parameter int                IR_W      = 4,
    parameter int                CHAIN_W   = 5,
    parameter logic [IR_W-1:0]   SEL_INSTR = 4'h2,
    parameter logic [IR_W-1:0]   ACC_INSTR = 4'hC,
    parameter logic [CHAIN_W-1:0] ACC_CHAIN = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IR_W-1:0] ir_value,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            tdi,
    output logic            chain_tdo,
    output logic            sel_active,
    output logic            acc_active
);

    logic [CHAIN_W-1:0] chain_sr;
    logic [CHAIN_W-1:0] chain_num;

    assign sel_active = (ir_value == SEL_INSTR);
    assign acc_active = (ir_value == ACC_INSTR) && (chain_num == ACC_CHAIN);
    assign chain_tdo  = chain_sr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_sr  <= '0;
            chain_num <= '1;
        end else if (sel_active) begin
            if (capture_dr)
                chain_sr <= chain_num;
            else if (shift_dr)
                chain_sr <= {tdi, chain_sr[CHAIN_W-1:1]};
            if (update_dr)
                chain_num <= chain_sr;
        end
    end

    // R2: the chain number moves only on an update under the select instruction
    p_chain_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(update_dr && sel_active) |=> $stable(chain_num));

endmodule

// File: rtl/jrac_access_shifter.sv
module jrac_access_shifter
    import jrac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   capture_dr,
    input  logic   shift_dr,
    input  logic   tdi,
    input  frame_t cap_load,
    output frame_t frame,
    output logic   acc_tdo
);

    assign acc_tdo = frame[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
        end else if (active) begin
            if (capture_dr)
                frame <= cap_load;
            else if (shift_dr)
                frame <= {tdi, frame[FRAME_W-1:1]};
        end
    end

    // R4: a shifted bit enters at the direction-flag end of the frame
    p_shift_in_r4: assert property (@(posedge clk) disable iff (rst)
        (active && shift_dr && !capture_dr) |=> (frame.wr == $past(tdi)));

endmodule

// File: rtl/jrac_reg_decode.sv
module jrac_reg_decode
    import jrac_pkg::*;
#(
    parameter int                NUM_REGS = 9,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h4A52_4143
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              capture_dr,
    input  logic              update_dr,
    input  frame_t            frame,
    output frame_t            cap_load,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);

    pend_t pend;
    rsrc_e src;
    logic  upd_fire;

    assign upd_fire = active && update_dr;
    assign src      = classify(pend.addr, NREG_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (upd_fire) begin
            pend.valid <= !frame.wr;
            pend.addr  <= frame.addr;
        end
    end

    always_comb begin
        cap_load = '0;
        if (pend.valid) begin
            unique case (src)
                SRC_IDENT: cap_load.data = ID_VALUE;
                SRC_BUS:   cap_load.data = bus_rdata;
                default:   cap_load.data = '0;
            endcase
        end
    end

    assign bus_re    = active && capture_dr && pend.valid && (src == SRC_BUS);
    assign bus_we    = upd_fire && frame.wr && writable(frame.addr, NREG_A);
    assign bus_addr  = update_dr ? frame.addr : pend.addr;
    assign bus_wdata = frame.data;

    // R9: an applied write frame leaves no read to serve at the next capture
    p_write_clears_pend_r9: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && frame.wr) |=> !pend.valid);

    // R6: no bus strobe ever names the identification slot or a missing register
    p_strobe_range_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we || bus_re) |-> (bus_addr != '0 && bus_addr < NREG_A));

    // R7: a read strobe is served only from a read recorded at an earlier update
    p_read_from_pend_r7: assert property (@(posedge clk) disable iff (rst)
        bus_re |-> !$past(upd_fire && frame.wr));

endmodule

// File: rtl/jtag_reg_access.sv
module jtag_reg_access
    import jrac_pkg::*;
#(
    parameter int                IR_W      = 4,
    parameter int                CHAIN_W   = 5,
    parameter int                NUM_REGS  = 9,
    parameter logic [IR_W-1:0]   SEL_INSTR = 4'h2,
    parameter logic [IR_W-1:0]   ACC_INSTR = 4'hC,
    parameter logic [DATA_W-1:0] ID_VALUE  = 32'h4A52_4143
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir_value,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic   chain_tdo;
    logic   acc_tdo;
    logic   sel_active;
    logic   acc_active;
    frame_t frame;
    frame_t cap_load;

    jrac_chain_select #(
        .IR_W      (IR_W),
        .CHAIN_W   (CHAIN_W),
        .SEL_INSTR (SEL_INSTR),
        .ACC_INSTR (ACC_INSTR),
        .ACC_CHAIN ('0)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .ir_value   (ir_value),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .chain_tdo  (chain_tdo),
        .sel_active (sel_active),
        .acc_active (acc_active)
    );

    jrac_access_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .active     (acc_active),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .cap_load   (cap_load),
        .frame      (frame),
        .acc_tdo    (acc_tdo)
    );

    jrac_reg_decode #(
        .NUM_REGS (NUM_REGS),
        .ID_VALUE (ID_VALUE)
    ) u_decode (
        .clk        (clk),
        .rst        (rst),
        .active     (acc_active),
        .capture_dr (capture_dr),
        .update_dr  (update_dr),
        .frame      (frame),
        .cap_load   (cap_load),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_rdata  (bus_rdata)
    );

    always_comb begin
        if (sel_active)
            tdo = chain_tdo;
        else if (acc_active)
            tdo = acc_tdo;
        else
            tdo = 1'b0;
    end

    // R3: no bus strobe while the access register is out of the path
    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !(ir_value == ACC_INSTR) |-> !(bus_we || bus_re));

endmodule

// File: tb/test_jtag_reg_access.sv
module test_jtag_reg_access;

    localparam logic [31:0] ID_V = 32'h4A52_4143;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ir_value = 4'h0;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we, bus_re;
    logic [31:0] bus_rdata;

    always #4 clk = ~clk;

    jtag_reg_access i_jtag_reg_access (
        .clk(clk), .rst(rst), .ir_value(ir_value),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    // Storage behind the bus: registers 1..8, RAM port at 4 with a read pointer.
    logic [31:0] st [9];
    logic [31:0] rp;
    assign bus_rdata = (bus_addr == 7'd4) ? (32'hA500_0000 + rp) :
                       (bus_addr < 7'd9) ? st[bus_addr[3:0]] : 32'h0;

    always @(posedge clk) begin
        if (rst) begin
            rp <= 0;
            for (int i = 0; i < 9; i++) st[i] <= 32'h5100_0000 + i * 32'h0001_0101;
        end else begin
            if (bus_we && bus_addr < 7'd9) st[bus_addr[3:0]] <= bus_wdata;
            if (bus_re && bus_addr == 7'd4) rp <= rp + 1;
        end
    end

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input logic [39:0] act, input logic [39:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard of expected bus events
    typedef struct { bit we; logic [6:0] addr; logic [31:0] data; string tag; } ev_t;
    ev_t evq[$];

    always begin
        @(negedge clk); #3;
        if (!rst && (bus_we || bus_re)) begin
            n_cmp++;
            if (bus_we && bus_re) begin
                n_bad++;
                $display("FAIL R5 both strobes actual=11 expected=one");
            end else if (evq.size() == 0) begin
                n_bad++;
                $display("FAIL R3/R6/R8/R9 unexpected event actual we=%0d re=%0d addr=%0d expected=none",
                         bus_we, bus_re, bus_addr);
            end else begin
                ev_t e;
                e = evq.pop_front();
                if (e.we != bus_we || e.addr != bus_addr || (e.we && e.data != bus_wdata)) begin
                    n_bad++;
                    $display("FAIL %s actual we=%0d addr=%0d data=%h expected we=%0d addr=%0d data=%h",
                             e.tag, bus_we, bus_addr, bus_wdata, e.we, e.addr, e.data);
                end
            end
        end
    end

    // Bench model of selection and pending read
    logic [4:0] m_chain = 5'h1F;
    bit         m_pend = 0;
    logic [6:0] m_paddr = 0;

    function automatic logic [31:0] exp_read(input logic [6:0] a);
        if (a == 0) return ID_V;
        if (a == 4) return 32'hA500_0000 + rp;
        if (a < 9) return st[a[3:0]];
        return 32'h0;
    endfunction

    task automatic run_scan(input int n, input logic [39:0] vin, output logic [39:0] vout);
        vout = '0;
        @(negedge clk); capture_dr = 1;
        @(negedge clk); capture_dr = 0;
        for (int i = 0; i < n; i++) begin
            shift_dr = 1; tdi = vin[i];
            #1 vout[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 0; update_dr = 1;
        @(negedge clk); update_dr = 0;
    endtask

    task automatic chain_scan(input logic [4:0] val, input string tag);
        logic [39:0] o;
        logic [4:0]  exp_o;
        exp_o = (ir_value == 4'h2) ? m_chain : 5'h0;
        run_scan(5, {35'h0, val}, o);
        chk({35'h0, o[4:0]}, {35'h0, exp_o}, tag);
        if (ir_value == 4'h2) m_chain = val;
    endtask

    task automatic acc_scan(input bit wr, input logic [6:0] a, input logic [31:0] d, input string tag);
        logic [39:0] o, exp_o;
        bit act;
        ev_t e;
        act = (ir_value == 4'hC) && (m_chain == 0);
        exp_o = '0;
        if (act && m_pend) begin
            exp_o[31:0] = exp_read(m_paddr);
            if (m_paddr != 0 && m_paddr < 9) begin
                e.we = 0; e.addr = m_paddr; e.data = 0; e.tag = {tag, " R7 read strobe"};
                evq.push_back(e);
            end
        end
        if (act && wr && a != 0 && a < 9) begin
            e.we = 1; e.addr = a; e.data = d; e.tag = {tag, " R5 write strobe"};
            evq.push_back(e);
        end
        run_scan(40, {wr, a, d}, o);
        chk(o, exp_o, tag);
        if (act) begin m_pend = !wr; m_paddr = a; end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #3;
        chk({37'h0, tdo, bus_we, bus_re}, 40'h0, "R1 reset outputs");

        // R1/R3: access instruction but chain still all ones
        ir_value = 4'hC;
        acc_scan(1, 7'd5, 32'hDEAD_0005, "R1 R3 write before chain select");
        // R10: unrelated instruction, tdo stays low
        ir_value = 4'h7;
        acc_scan(0, 7'd1, 32'h0, "R10 idle instruction tdo");

        // R2: chain selection
        ir_value = 4'h2;
        chain_scan(5'h00, "R2 capture reset chain number");
        chain_scan(5'h00, "R2 capture chain zero");

        ir_value = 4'hC;
        acc_scan(0, 7'd1, 32'h0, "R9 capture with nothing pending");
        acc_scan(0, 7'd2, 32'h0, "R7 R4 read reg1");
        acc_scan(1, 7'd7, 32'hCAFE_0007, "R7 read reg2");
        acc_scan(0, 7'd7, 32'h0, "R9 capture after write");
        acc_scan(0, 7'd4, 32'h0, "R5 readback reg7");
        acc_scan(0, 7'd4, 32'h0, "R7 RAM entry 0");
        acc_scan(0, 7'd0, 32'h0, "R7 RAM entry 1");
        acc_scan(0, 7'h55, 32'h0, "R8 identification");
        acc_scan(1, 7'd0, 32'h1111_1111, "R8 out of range reads zero");
        acc_scan(1, 7'd9, 32'h2222_2222, "R6 write to id no strobe");
        acc_scan(0, 7'd8, 32'h0, "R6 write above range no strobe");
        acc_scan(0, 7'd3, 32'h0, "R7 read reg8");
        acc_scan(0, 7'd0, 32'h0, "R7 read reg3");
        chk({8'h0, rp}, 40'd2, "R8 RAM pointer moved only twice");

        // R3: move to chain 3, access register leaves the path
        ir_value = 4'h2;
        chain_scan(5'h03, "R2 capture before chain 3");
        ir_value = 4'hC;
        acc_scan(1, 7'd5, 32'hBEEF_0005, "R3 write on wrong chain");
        ir_value = 4'h2;
        chain_scan(5'h00, "R2 capture chain 3");
        ir_value = 4'hC;
        acc_scan(0, 7'd5, 32'h0, "R3 pending id served after reselect");
        acc_scan(0, 7'd0, 32'h0, "R3 reg5 untouched");

        repeat (4) @(negedge clk);
        n_cmp++;
        if (evq.size() != 0) begin
            n_bad++;
            $display("FAIL R5/R7 missing events actual=%0d expected=0", evq.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule